// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Block

This block holds the transmit and receive word queues of a synchronous serial port and derives from them the port's status word and its two interrupt request lines. The register bus pushes words for transmission and pops received words. The shift engine pops transmit words and pushes received ones. Each queue is 16 words deep and hands out its words in arrival order. The head word is always visible on a read-data port.

Software programs a 4-bit threshold field for each direction. The field holds the wanted threshold minus one, so the effective threshold T is field+1, in the range 1..16. The transmit service flag asks for more data while the transmit level is at or below T. The receive service flag asks for draining once the receive level reaches T. A received word that finds the receive queue full is dropped, and a sticky overrun flag is raised. A write-1 clear strobe resets that flag. Three test inputs force the transmit service, receive service and overrun indications on, whatever state the queues are in, so that interrupt paths can be exercised.

Each queue runs a fill state machine with three states: EMPTY, PART and FULL. Moves go between neighbouring states only. EMPTY goes to PART on a lone push. PART goes to EMPTY when a lone pop takes the last word, and to FULL when a lone push fills the last slot. FULL goes to PART on a lone pop. A push together with a pop keeps the state. The overrun flag has its own state machine with two states, CLEAR and SET. CLEAR goes to SET on a dropped receive word. SET goes back to CLEAR on a clear strobe that comes without a new drop.

Top module: `sfifo_irq_top`

## Requirements
- R1: The status word reports transmit-not-full at bit 2, receive-not-empty at bit 3 and the shift engine busy input at bit 4. Bits 1:0 read 0. After reset both queues are empty, so bit 2 = 1 and bit 3 = 0.
- R2: The transmit level is reported at bits 11:8 and the receive level at bits 15:12. A queue holding 16 words reports level 0, and bits 2 and 3 then tell full apart from empty.
- R3: Each queue returns words in the order they were pushed. Its read-data port shows the oldest word held.
- R4: A push into a full transmit queue is discarded, and a pop from an empty queue is ignored. In both cases the level stays unchanged.
- R5: A push and a pop in the same cycle on a non-empty queue leave its level unchanged. This includes a full queue, whose push is then accepted.
- R6: Status bit 5 (transmit service) is 1 when the transmit level is at most the transmit threshold field + 1.
- R7: Status bit 6 (receive service) is 1 when the receive level is at least the receive threshold field + 1.
- R8: A receive push into a full receive queue with no pop in the same cycle sets status bit 7 (overrun) on the next cycle. The word is discarded and the level stays at 16.
- R9: The overrun flag stays set until a cycle with the clear strobe. If a new overrun occurs in the same cycle as the clear strobe, the flag stays set.
- R10: The transmit request equals the transmit enable AND bit 5. The receive request equals (the receive enable AND bit 6) OR bit 7. An overrun is therefore requested even while the receive enable is off.
- R11: Each test input forces its status bit (5, 6 or 7) and the matching request active while the input is held. Releasing the input restores the value derived from the queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Write a word into the transmit queue |
| tx_wdata | input | 16 | Word to write into the transmit queue |
| tx_pop | input | 1 | Shift engine takes the transmit head word |
| tx_rdata | output | 16 | Transmit head word |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_wdata | input | 16 | Received word |
| rx_pop | input | 1 | Bus reads the receive head word |
| rx_rdata | output | 16 | Receive head word |
| busy_in | input | 1 | Shift engine busy, reported at bit 4 |
| tx_thr | input | 4 | Transmit threshold minus one |
| rx_thr | input | 4 | Receive threshold minus one |
| tx_irq_en | input | 1 | Transmit service request enable |
| rx_irq_en | input | 1 | Receive service request enable |
| test_tx_svc | input | 1 | Force transmit service |
| test_rx_svc | input | 1 | Force receive service |
| test_rx_ovr | input | 1 | Force overrun indication |
| ovr_clr | input | 1 | Write-1 clear of the overrun flag |
| status | output | 16 | Status word |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A fill state that has drifted from the true count shows up at the ports in the next cycle. The level field, the not-full and not-empty bits, and both service flags are all read from the state registers without delay, so a wrong fill state disagrees with them at once. A read pointer that has slipped goes unnoticed until the queue is drained, when the head word on the read-data port comes out of order. An overrun flag that fails to hold is seen only one cycle after the drop, and only if the bench reads bit 7 again after that cycle with no clear strobe, so the bench checks it after a full drain.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_t;

    typedef enum logic {
        OVR_CLEAR = 1'b0,
        OVR_SET   = 1'b1
    } ovr_state_t;

    localparam int unsigned BIT_TNF = 2;
    localparam int unsigned BIT_RNE = 3;
    localparam int unsigned BIT_BSY = 4;
    localparam int unsigned BIT_TSV = 5;
    localparam int unsigned BIT_RSV = 6;
    localparam int unsigned BIT_OVR = 7;
    localparam int unsigned LVL_LSB = 8;
endpackage

// File: rtl/sfifo_buf.sv
module sfifo_buf
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              drop
);
    fill_state_t            state, state_nxt;
    logic [DATA_W-1:0]      mem [DEPTH];
    logic [PTR_W-1:0]       wr_ptr, rd_ptr;
    logic [CNT_W-1:0]       cnt_nxt;
    logic                   do_push, do_pop;

    // pop/push acceptance per state
    always_comb begin
        do_pop  = 1'b0;
        do_push = 1'b0;
        unique case (state)
            FILL_EMPTY: begin
                do_pop  = 1'b0;
                do_push = push;
            end
            FILL_PART: begin
                do_pop  = pop;
                do_push = push;
            end
            FILL_FULL: begin
                do_pop  = pop;
                do_push = push && pop;
            end
            default: begin
                do_pop  = 1'b0;
                do_push = 1'b0;
            end
        endcase
        cnt_nxt = count;
        if (do_push && !do_pop) cnt_nxt = count + 1'b1;
        else if (do_pop && !do_push) cnt_nxt = count - 1'b1;
        if (cnt_nxt == '0) state_nxt = FILL_EMPTY;
        else if (cnt_nxt == CNT_W'(DEPTH)) state_nxt = FILL_FULL;
        else state_nxt = FILL_PART;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FILL_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nxt;
            count <= cnt_nxt;
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // outputs
    always_comb begin
        full  = (state == FILL_FULL);
        empty = (state == FILL_EMPTY);
        drop  = push && !do_push;
        rdata = mem[rd_ptr];
    end

    // R4
    push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_FULL && push && !pop) |=> (count == CNT_W'(DEPTH)));
    // R4
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_EMPTY && pop && !push) |=> (state == FILL_EMPTY));
    // R5
    push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && state != FILL_EMPTY) |=> $stable(count));
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/sfifo_ovr.sv
module sfifo_ovr
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    ovr_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            OVR_CLEAR: if (hit) state_nxt = OVR_SET;
            OVR_SET:   if (clr && !hit) state_nxt = OVR_CLEAR;
            default:   state_nxt = OVR_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OVR_CLEAR;
        else        state <= state_nxt;
    end

    always_comb flag = (state == OVR_SET);

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/sfifo_thresh.sv
module sfifo_thresh #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned THR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic             tx_svc,
    output logic             rx_svc
);
    logic [CNT_W-1:0] tx_lim, rx_lim;

    always_comb begin
        tx_lim = CNT_W'(tx_thr) + 1'b1;
        rx_lim = CNT_W'(rx_thr) + 1'b1;
        tx_svc = (tx_cnt <= tx_lim);
        rx_svc = (rx_cnt >= rx_lim);
    end
endmodule

// File: rtl/sfifo_irq_top.sv
module sfifo_irq_top
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned LVL_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned STAT_W = LVL_LSB + 2 * LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              busy_in,
    input  logic [LVL_W-1:0]  tx_thr,
    input  logic [LVL_W-1:0]  rx_thr,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              test_tx_svc,
    input  logic              test_rx_svc,
    input  logic              test_rx_ovr,
    input  logic              ovr_clr,
    output logic [STAT_W-1:0] status,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic tx_full, tx_empty, tx_drop;
    logic rx_full, rx_empty, rx_drop;
    logic tx_svc, rx_svc, ovr_flag;
    logic tsv_eff, rsv_eff, ovr_eff;

    sfifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .wdata(tx_wdata), .rdata(tx_rdata), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty), .drop(tx_drop)
    );

    sfifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .wdata(rx_wdata), .rdata(rx_rdata), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty), .drop(rx_drop)
    );

    sfifo_thresh #(.DEPTH(DEPTH)) u_thr (
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_svc(tx_svc), .rx_svc(rx_svc)
    );

    sfifo_ovr u_ovr (
        .clk(clk), .rst_n(rst_n), .hit(rx_drop), .clr(ovr_clr), .flag(ovr_flag)
    );

    always_comb begin
        tsv_eff = tx_svc | test_tx_svc;
        rsv_eff = rx_svc | test_rx_svc;
        ovr_eff = ovr_flag | test_rx_ovr;
        status = '0;
        status[BIT_TNF] = !tx_full;
        status[BIT_RNE] = !rx_empty;
        status[BIT_BSY] = busy_in;
        status[BIT_TSV] = tsv_eff;
        status[BIT_RSV] = rsv_eff;
        status[BIT_OVR] = ovr_eff;
        status[LVL_LSB +: LVL_W]         = tx_cnt[LVL_W-1:0];
        status[LVL_LSB + LVL_W +: LVL_W] = rx_cnt[LVL_W-1:0];
        tx_irq = tx_irq_en & tsv_eff;
        rx_irq = (rx_irq_en & rsv_eff) | ovr_eff;
    end

    // R11
    test_ovr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_rx_ovr |-> rx_irq);
    // R10
    ovr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> rx_irq);
    // R1
    tx_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_empty);
    // R4
    tx_drop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drop |=> $stable(tx_cnt));
endmodule

// File: tb/sim_sfifo_irq_top.sv
module sim_sfifo_irq_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, busy_in = 0;
    logic [15:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
    logic [3:0] tx_thr = 4'd3, rx_thr = 4'd1;
    logic tx_irq_en = 0, rx_irq_en = 0;
    logic test_tx_svc = 0, test_rx_svc = 0, test_rx_ovr = 0, ovr_clr = 0;
    logic [15:0] status;
    logic tx_irq, rx_irq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sfifo_irq_top u0 (
        .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .rx_push(rx_push), .rx_wdata(rx_wdata),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .busy_in(busy_in), .tx_thr(tx_thr),
        .rx_thr(rx_thr), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .test_tx_svc(test_tx_svc), .test_rx_svc(test_rx_svc), .test_rx_ovr(test_rx_ovr),
        .ovr_clr(ovr_clr), .status(status), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, release just after posedge
    task automatic cyc(input logic tp, input logic tq, input logic rp, input logic rq,
                       input logic [15:0] tw, input logic [15:0] rw, input logic clr);
        @(negedge clk);
        tx_push = tp; tx_pop = tq; rx_push = rp; rx_pop = rq;
        tx_wdata = tw; rx_wdata = rw; ovr_clr = clr;
        @(posedge clk); #1;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; ovr_clr = 0;
    endtask

    task automatic t_reset();
        chk("R1 tnf", 32'(status[2]), 1);
        chk("R1 rne", 32'(status[3]), 0);
        chk("R1 low bits", 32'(status[1:0]), 0);
        busy_in = 1; #1;
        chk("R1 busy", 32'(status[4]), 1);
        busy_in = 0; #1;
        chk("R2 levels", 32'(status[15:8]), 0);
    endtask

    task automatic t_tx_fill();
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 16'h100 + 16'(i), 0, 0);
        chk("R6 level5 above T4", 32'(status[5]), 0);
        tx_irq_en = 1; #1;
        chk("R10 tx_irq off", 32'(tx_irq), 0);
        cyc(0, 1, 0, 0, 0, 0, 0);
        chk("R6 level4 at T4", 32'(status[5]), 1);
        chk("R10 tx_irq on", 32'(tx_irq), 1);
        chk("R3 tx head", 32'(tx_rdata), 32'h101);
        for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, 16'h200 + 16'(i), 0, 0);
        chk("R2 tx full wraps", 32'(status[11:8]), 0);
        chk("R2 tnf low when full", 32'(status[2]), 0);
        cyc(1, 0, 0, 0, 16'hBEEF, 0, 0);
        chk("R4 push full ignored", 32'(status[11:8]), 0);
        chk("R4 still full", 32'(status[2]), 0);
        cyc(1, 1, 0, 0, 16'h300, 0, 0);
        chk("R5 full push+pop level", 32'(status[11:8]), 0);
        chk("R5 full push+pop still full", 32'(status[2]), 0);
        chk("R3 tx next head", 32'(tx_rdata), 32'h102);
        tx_irq_en = 0;
    endtask

    task automatic t_tx_drain();
        for (int i = 0; i < 16; i++) cyc(0, 1, 0, 0, 0, 0, 0);
        chk("R2 tx empty", 32'(status[11:8]), 0);
        chk("R2 tx empty tnf", 32'(status[2]), 1);
        cyc(0, 1, 0, 0, 0, 0, 0);
        chk("R4 pop empty ignored", 32'(status[11:8]), 0);
        cyc(1, 0, 0, 0, 16'h0AA, 0, 0);
        chk("R4 push after empty pop", 32'(status[11:8]), 1);
        chk("R3 tx single", 32'(tx_rdata), 32'h0AA);
        cyc(0, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_rx_thresh();
        rx_irq_en = 1;
        cyc(0, 0, 1, 0, 0, 16'h11, 0);
        chk("R7 level1 below T2", 32'(status[6]), 0);
        chk("R10 rx_irq off", 32'(rx_irq), 0);
        cyc(0, 0, 1, 0, 0, 16'h22, 0);
        chk("R7 level2 at T2", 32'(status[6]), 1);
        chk("R10 rx_irq on", 32'(rx_irq), 1);
        chk("R1 rne", 32'(status[3]), 1);
        cyc(0, 0, 1, 1, 0, 16'h33, 0);
        chk("R5 rx push+pop level", 32'(status[15:12]), 2);
        chk("R3 rx head", 32'(rx_rdata), 32'h22);
        rx_irq_en = 0; #1;
        chk("R10 rx_irq gated", 32'(rx_irq), 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R2 rx empty", 32'(status[3]), 0);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, 0, 16'h400 + 16'(i), 0);
        chk("R2 rx full wraps", 32'(status[15:12]), 0);
        chk("R8 no overrun yet", 32'(status[7]), 0);
        cyc(0, 0, 1, 0, 0, 16'hDEAD, 0);
        chk("R8 overrun set", 32'(status[7]), 1);
        chk("R10 overrun irq ungated", 32'(rx_irq), 1);
        for (int i = 0; i < 16; i++) begin
            chk("R8 rx order no drop", 32'(rx_rdata), 32'h400 + 32'(i));
            cyc(0, 0, 0, 1, 0, 0, 0);
        end
        chk("R8 rx empty after drain", 32'(status[3]), 0);
        chk("R9 sticky", 32'(status[7]), 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R9 cleared", 32'(status[7]), 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, 0, 16'(i), 0);
        cyc(0, 0, 1, 0, 0, 16'hDEAD, 1);
        chk("R9 set wins over clear", 32'(status[7]), 1);
        cyc(0, 0, 1, 1, 0, 16'h77, 1);
        chk("R9 clear with push+pop", 32'(status[7]), 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic t_test_force();
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 16'(i), 0, 0);
        tx_irq_en = 1; rx_irq_en = 1; #1;
        chk("R11 tsv baseline", 32'(status[5]), 0);
        test_tx_svc = 1; #1;
        chk("R11 tsv forced", 32'(status[5]), 1);
        chk("R11 tx_irq forced", 32'(tx_irq), 1);
        test_tx_svc = 0; test_rx_svc = 1; #1;
        chk("R11 tsv released", 32'(status[5]), 0);
        chk("R11 rsv forced", 32'(status[6]), 1);
        chk("R11 rx_irq forced", 32'(rx_irq), 1);
        test_rx_svc = 0; rx_irq_en = 0; test_rx_ovr = 1; #1;
        chk("R11 ovr forced", 32'(status[7]), 1);
        chk("R11 ovr irq", 32'(rx_irq), 1);
        test_rx_ovr = 0;
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R11 ovr not sticky", 32'(status[7]), 0);
        chk("R11 rx_irq released", 32'(rx_irq), 0);
        tx_irq_en = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_tx_fill();
        t_tx_drain();
        t_rx_thresh();
        t_overrun();
        t_test_force();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule